// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block sits on a pixel output path and limits each of the three colour components of every valid pixel to a window. A 3-bit format code picks the window. Codes for 8, 10 and 12 bits per component select a fixed studio-range window. A separate code switches each channel to its own programmable lower and upper bound. A clamp-enable bit of 0 gives full-range operation: pixels go through untouched. Components are 12 bits wide and MSB-aligned, so narrower windows are scaled up before the comparison. For the default width, all three fixed windows come out as 256..3760.

The result is registered: a pixel presented with `in_valid` high appears one clock later with `out_valid` high. A change of the enable or format setting never goes straight from one active setting to another. The applied setting first drops to enable 0 and format 0 for one cycle, then takes the new value. Bound registers are written through one strobe per channel and come out of reset with a lower bound of 0x010 and an upper bound of 0xFEF.

Top module: `pix_range_clamp`

## Requirements
- R1: While reset is held and after it is released, before any pixel is accepted, `out_valid` is 0 and all three output components are 0.
- R2: `out_valid` equals `in_valid` of the previous clock cycle, and a pixel accepted in one cycle appears on the outputs in the next.
- R3: With the applied enable at 0, each output component equals its input component, whatever the format code.
- R4: With the applied enable at 1, format codes 0 (6 bits, no clamping), 4, 5 and 6 pass each component through unchanged.
- R5: Format codes 1, 2 and 3 clamp every component to the 8-bit window 16..235 scaled by 16, the 10-bit window 64..940 scaled by 4, or the 12-bit window 256..3760; at 12 bits each of these is 256..3760.
- R6: Format code 7 clamps each channel to its own programmable window: values below the channel's lower bound give the lower bound, values above its upper bound give the upper bound.
- R7: After reset every channel's programmable lower bound is 0x010 and its upper bound is 0xFEF.
- R8: If a programmable lower bound is greater than its upper bound, that channel's output under code 7 equals the upper bound for every input.
- R9: When the requested enable/format pair differs from the applied pair and the applied pair is not (0,0), the applied pair becomes (0,0) for one cycle before the requested pair applies. A pixel accepted in the cycle of the request uses the old setting, the next one passes through, and the one after uses the new setting.
- R10: Strobe bit 0, 1 or 2 of `bnd_we` loads `bnd_lo_in`/`bnd_hi_in` into the R, G or B bounds. Pixels accepted from the following cycle on use the new bounds, and the bounds of channels whose strobe bit is 0 are unchanged.
- R11: In a cycle with `in_valid` low, the output components keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | DATA_W | Red component, MSB-aligned |
| in_g | input | DATA_W | Green component, MSB-aligned |
| in_b | input | DATA_W | Blue component, MSB-aligned |
| clamp_en | input | 1 | Requested clamp enable (0 = full range) |
| fmt_code | input | 3 | Requested format code |
| bnd_we | input | 3 | Bound write strobes, bit 0 R, bit 1 G, bit 2 B |
| bnd_lo_in | input | DATA_W | Lower bound write data |
| bnd_hi_in | input | DATA_W | Upper bound write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | DATA_W | Clamped red component |
| out_g | output | DATA_W | Clamped green component |
| out_b | output | DATA_W | Clamped blue component |

## Verification
The range and pass-through properties are keyed on the applied enable/format pair inside the block, not on the raw request pins. They therefore do not depend on how the request moves. They do assume the input pins carry known values in every cycle after reset, and the upper-bound property for code 7 compares against the bound held in the cycle the pixel was accepted. The stimulus drives every input from time zero, keeps clamp-enable at 0 through reset, and changes the configuration or bounds only between pixels or in deliberate R9/R10 sequences. The scoreboard replays the two-step configuration rule on its own.

// File: rtl/pix_clamp_pkg.sv
package pix_clamp_pkg;

   localparam int FMT_W = 3;

   typedef enum logic [FMT_W-1:0] {
      FMT_NOCLAMP = 3'd0,
      FMT_STUDIO8 = 3'd1,
      FMT_STUDIO10 = 3'd2,
      FMT_STUDIO12 = 3'd3,
      FMT_PROG = 3'd7
   } fmt_e;

   // studio-range window limits at each native component width
   localparam int LO_AT8 = 16;
   localparam int HI_AT8 = 235;
   localparam int LO_AT10 = 64;
   localparam int HI_AT10 = 940;
   localparam int LO_AT12 = 256;
   localparam int HI_AT12 = 3760;

endpackage

// File: rtl/pix_clamp_cfg_seq.sv
module pix_clamp_cfg_seq
   import pix_clamp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_en,
   input  logic [FMT_W-1:0] req_fmt,
   output logic             app_en,
   output logic [FMT_W-1:0] app_fmt
);
   localparam int CFG_W = FMT_W + 1;

   logic [CFG_W-1:0] req_cfg;
   logic [CFG_W-1:0] app_cfg;
   logic             app_idle;
   logic             changing;

   assign req_cfg  = {req_en, req_fmt};
   assign app_idle = (app_cfg == '0);
   assign changing = (req_cfg != app_cfg);

   // a live setting is always cleared for one cycle before the next applies
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         app_cfg <= '0;
      end else if (changing && !app_idle) begin
         app_cfg <= '0;
      end else begin
         app_cfg <= req_cfg;
      end
   end

   assign app_en  = app_cfg[CFG_W-1];
   assign app_fmt = app_cfg[FMT_W-1:0];
endmodule

// File: rtl/pix_clamp_bounds.sv
module pix_clamp_bounds #(
   parameter int DATA_W = 12,
   parameter int NUM_CH = 3,
   parameter logic [DATA_W-1:0] LO_RST = 12'h010,
   parameter logic [DATA_W-1:0] HI_RST = 12'hFEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        we,
   input  logic [DATA_W-1:0]        lo_in,
   input  logic [DATA_W-1:0]        hi_in,
   output logic [NUM_CH*DATA_W-1:0] lo_vec,
   output logic [NUM_CH*DATA_W-1:0] hi_vec
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] lo_q;
      logic [DATA_W-1:0] hi_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
         end else if (we[c]) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
         end
      end

      assign lo_vec[c*DATA_W +: DATA_W] = lo_q;
      assign hi_vec[c*DATA_W +: DATA_W] = hi_q;
   end
endmodule

// File: rtl/pix_clamp_lane.sv
module pix_clamp_lane
   import pix_clamp_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              en,
   input  logic [FMT_W-1:0]  fmt,
   input  logic [DATA_W-1:0] prog_lo,
   input  logic [DATA_W-1:0] prog_hi,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam logic [DATA_W-1:0] W8_LO  = DATA_W'(LO_AT8)  << (DATA_W - 8);
   localparam logic [DATA_W-1:0] W8_HI  = DATA_W'(HI_AT8)  << (DATA_W - 8);
   localparam logic [DATA_W-1:0] W10_LO = DATA_W'(LO_AT10) << (DATA_W - 10);
   localparam logic [DATA_W-1:0] W10_HI = DATA_W'(HI_AT10) << (DATA_W - 10);
   localparam logic [DATA_W-1:0] W12_LO = DATA_W'(LO_AT12) << (DATA_W - 12);
   localparam logic [DATA_W-1:0] W12_HI = DATA_W'(HI_AT12) << (DATA_W - 12);

   logic              act;
   logic [DATA_W-1:0] lo_s;
   logic [DATA_W-1:0] hi_s;
   logic [DATA_W-1:0] floor_s;

   always_comb begin
      act  = en;
      lo_s = '0;
      hi_s = '1;
      case (fmt)
         FMT_STUDIO8: begin
            lo_s = W8_LO;
            hi_s = W8_HI;
         end
         FMT_STUDIO10: begin
            lo_s = W10_LO;
            hi_s = W10_HI;
         end
         FMT_STUDIO12: begin
            lo_s = W12_LO;
            hi_s = W12_HI;
         end
         FMT_PROG: begin
            lo_s = prog_lo;
            hi_s = prog_hi;
         end
         default: act = 1'b0;
      endcase
   end

   // floor first, ceiling last: an inverted window resolves to the ceiling
   always_comb begin
      floor_s = (din < lo_s) ? lo_s : din;
      if (!act) begin
         dout = din;
      end else if (floor_s > hi_s) begin
         dout = hi_s;
      end else begin
         dout = floor_s;
      end
   end
endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
   import pix_clamp_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter logic [DATA_W-1:0] PROG_LO_RST = 12'h010,
   parameter logic [DATA_W-1:0] PROG_HI_RST = 12'hFEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_r,
   input  logic [DATA_W-1:0] in_g,
   input  logic [DATA_W-1:0] in_b,
   input  logic              clamp_en,
   input  logic [2:0]        fmt_code,
   input  logic [2:0]        bnd_we,
   input  logic [DATA_W-1:0] bnd_lo_in,
   input  logic [DATA_W-1:0] bnd_hi_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_r,
   output logic [DATA_W-1:0] out_g,
   output logic [DATA_W-1:0] out_b
);
   localparam int NUM_CH = 3;
   localparam int VEC_W  = NUM_CH * DATA_W;

   if (DATA_W < 12) begin : g_bad_width
      $error("pix_range_clamp: DATA_W must be at least 12");
   end

   logic             app_en;
   logic [FMT_W-1:0] app_fmt;
   logic [VEC_W-1:0] lo_vec;
   logic [VEC_W-1:0] hi_vec;
   logic [VEC_W-1:0] pix_in;
   logic [VEC_W-1:0] pix_cl;
   logic [VEC_W-1:0] pix_q;

   assign pix_in = {in_b, in_g, in_r};

   pix_clamp_cfg_seq u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_en  (clamp_en),
      .req_fmt (fmt_code),
      .app_en  (app_en),
      .app_fmt (app_fmt)
   );

   pix_clamp_bounds #(
      .DATA_W (DATA_W),
      .NUM_CH (NUM_CH),
      .LO_RST (PROG_LO_RST),
      .HI_RST (PROG_HI_RST)
   ) u_bounds (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bnd_we),
      .lo_in  (bnd_lo_in),
      .hi_in  (bnd_hi_in),
      .lo_vec (lo_vec),
      .hi_vec (hi_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      pix_clamp_lane #(.DATA_W(DATA_W)) u_lane (
         .en      (app_en),
         .fmt     (app_fmt),
         .prog_lo (lo_vec[c*DATA_W +: DATA_W]),
         .prog_hi (hi_vec[c*DATA_W +: DATA_W]),
         .din     (pix_in[c*DATA_W +: DATA_W]),
         .dout    (pix_cl[c*DATA_W +: DATA_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         pix_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pix_q <= pix_cl;
         end
      end
   end

   assign out_r = pix_q[0*DATA_W +: DATA_W];
   assign out_g = pix_q[1*DATA_W +: DATA_W];
   assign out_b = pix_q[2*DATA_W +: DATA_W];
endmodule

// File: rtl/pix_range_clamp_chk.sv
module pix_range_clamp_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_r,
   input logic [DATA_W-1:0] in_g,
   input logic [DATA_W-1:0] in_b,
   input logic              app_en,
   input logic [2:0]        app_fmt,
   input logic [DATA_W-1:0] hi_r,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_r,
   input logic [DATA_W-1:0] out_g,
   input logic [DATA_W-1:0] out_b
);
   localparam logic [DATA_W-1:0] WIN_LO = DATA_W'(256)  << (DATA_W - 12);
   localparam logic [DATA_W-1:0] WIN_HI = DATA_W'(3760) << (DATA_W - 12);

   logic fixed_win;
   logic pass_code;
   assign fixed_win = app_en && (app_fmt >= 3'd1) && (app_fmt <= 3'd3);
   assign pass_code = app_en && ((app_fmt == 3'd0) || (app_fmt == 3'd4) ||
                                 (app_fmt == 3'd5) || (app_fmt == 3'd6));

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !app_en) |=>
         (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));
   assert_passcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pass_code) |=>
         (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));
   assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fixed_win) |=>
         (out_r >= WIN_LO && out_r <= WIN_HI && out_g >= WIN_LO && out_g <= WIN_HI &&
          out_b >= WIN_LO && out_b <= WIN_HI));
   assert_prog_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && app_en && app_fmt == 3'd7) |=> (out_r <= $past(hi_r)));
   assert_cfg_via_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past({app_en, app_fmt}) != 4'd0 && {app_en, app_fmt} != $past({app_en, app_fmt}))
         |-> ({app_en, app_fmt} == 4'd0));
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

bind pix_range_clamp pix_range_clamp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_r      (in_r),
   .in_g      (in_g),
   .in_b      (in_b),
   .app_en    (app_en),
   .app_fmt   (app_fmt),
   .hi_r      (hi_vec[DATA_W-1:0]),
   .out_valid (out_valid),
   .out_r     (out_r),
   .out_g     (out_g),
   .out_b     (out_b)
);

// File: tb/pix_range_clamp_tb.sv
module pix_range_clamp_tb;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_r = '0, in_g = '0, in_b = '0;
   logic          clamp_en = 1'b0;
   logic [2:0]    fmt_code = 3'd0;
   logic [2:0]    bnd_we = 3'd0;
   logic [DW-1:0] bnd_lo_in = '0, bnd_hi_in = '0;
   logic          out_valid;
   logic [DW-1:0] out_r, out_g, out_b;

   int checks = 0;
   int failures = 0;
   bit monitor_on = 0;
   bit finished = 0;

   // scoreboard
   logic [3*DW-1:0] exp_q[$];
   string           tag_q[$];
   logic [3*DW-1:0] last_out = '0;

   // model state
   logic          m_app_en = 1'b0;
   logic [2:0]    m_app_fmt = 3'd0;
   logic [DW-1:0] m_lo[3];
   logic [DW-1:0] m_hi[3];

   always #2 clk = ~clk;

   pix_range_clamp u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .clamp_en(clamp_en), .fmt_code(fmt_code),
      .bnd_we(bnd_we), .bnd_lo_in(bnd_lo_in), .bnd_hi_in(bnd_hi_in),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   function automatic logic [DW-1:0] ref_clamp(input logic [DW-1:0] x, input logic en,
                                                input logic [2:0] f, input logic [DW-1:0] lo,
                                                input logic [DW-1:0] hi);
      logic [DW-1:0] l, h, y;
      if (!en) return x;
      case (f)
         3'd1: begin l = 12'(16 * 16); h = 12'(235 * 16); end
         3'd2: begin l = 12'(64 * 4);  h = 12'(940 * 4);  end
         3'd3: begin l = 12'd256;      h = 12'd3760;      end
         3'd7: begin l = lo;           h = hi;            end
         default: return x;
      endcase
      y = (x < l) ? l : x;
      if (y > h) y = h;
      return y;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [3*DW-1:0] act,
                        input logic [3*DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cycle(input logic v, input logic [DW-1:0] r, input logic [DW-1:0] g,
                        input logic [DW-1:0] b, input string tag);
      in_valid = v;
      in_r = r; in_g = g; in_b = b;
      if (v) begin
         exp_q.push_back({ref_clamp(b, m_app_en, m_app_fmt, m_lo[2], m_hi[2]),
                          ref_clamp(g, m_app_en, m_app_fmt, m_lo[1], m_hi[1]),
                          ref_clamp(r, m_app_en, m_app_fmt, m_lo[0], m_hi[0])});
         tag_q.push_back(tag);
      end
      // R9 model: a live setting drops to (0,0) before another applies
      if ({clamp_en, fmt_code} != {m_app_en, m_app_fmt} && {m_app_en, m_app_fmt} != 4'd0)
         {m_app_en, m_app_fmt} = 4'd0;
      else
         {m_app_en, m_app_fmt} = {clamp_en, fmt_code};
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, in_r, in_g, in_b, "R11");
   endtask

   task automatic write_bounds(input logic [2:0] mask, input logic [DW-1:0] lo,
                               input logic [DW-1:0] hi);
      bnd_we = mask; bnd_lo_in = lo; bnd_hi_in = hi;
      idle(1);
      bnd_we = 3'd0;
      for (int c = 0; c < 3; c++) if (mask[c]) begin m_lo[c] = lo; m_hi[c] = hi; end
   endtask

   task automatic set_cfg(input logic en, input logic [2:0] f);
      clamp_en = en; fmt_code = f;
      idle(3);
   endtask

   task automatic sweep(input string tag);
      for (int x = 0; x < 4096; x++)
         cycle(1'b1, DW'(x), DW'(4095 - x), DW'((x * 5 + 123) % 4096), tag);
   endtask

   // monitor
   always @(negedge clk) begin
      if (monitor_on && rst_n) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", {out_b, out_g, out_r}, '0);
            end else begin
               logic [3*DW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({out_b, out_g, out_r} == e, t, {out_b, out_g, out_r}, e);
            end
         end else begin
            // R11: outputs hold while no pixel arrives
            check({out_b, out_g, out_r} == last_out, "R11", {out_b, out_g, out_r}, last_out);
         end
         last_out = {out_b, out_g, out_r};
      end
   end

   initial begin
      for (int c = 0; c < 3; c++) begin m_lo[c] = 12'h010; m_hi[c] = 12'hFEF; end
      repeat (4) @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0 && {out_b, out_g, out_r} == '0, "R1",
            {out_b, out_g, out_r}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && {out_b, out_g, out_r} == '0, "R1",
            {out_b, out_g, out_r}, '0);
      monitor_on = 1;

      // R2: single pixel then gap
      cycle(1'b1, 12'h123, 12'h456, 12'h789, "R2");
      idle(2);

      // R7: default programmable bounds
      set_cfg(1'b1, 3'd7);
      cycle(1'b1, 12'h000, 12'hFFF, 12'h800, "R7");
      cycle(1'b1, 12'h00F, 12'hFF0, 12'h010, "R7");
      idle(2);

      // R4 / R5: every format with clamping on
      for (int f = 0; f < 7; f++) begin
         set_cfg(1'b1, 3'(f));
         sweep((f >= 1 && f <= 3) ? "R5" : "R4");
      end

      // R6: distinct per-channel windows
      write_bounds(3'b001, 12'h100, 12'hE00);
      write_bounds(3'b010, 12'h040, 12'hF80);
      write_bounds(3'b100, 12'h200, 12'h300);
      set_cfg(1'b1, 3'd7);
      sweep("R6");

      // R3: clamp disabled with clamping codes requested
      set_cfg(1'b0, 3'd3);
      sweep("R3");
      set_cfg(1'b0, 3'd7);
      sweep("R3");

      // R10: write only G, pixel right after the write
      set_cfg(1'b1, 3'd7);
      bnd_we = 3'b010; bnd_lo_in = 12'h500; bnd_hi_in = 12'h600;
      cycle(1'b0, 12'h000, 12'h000, 12'h000, "R10");
      bnd_we = 3'b000; m_lo[1] = 12'h500; m_hi[1] = 12'h600;
      cycle(1'b1, 12'h000, 12'h000, 12'h000, "R10");
      cycle(1'b1, 12'hFFF, 12'hFFF, 12'hFFF, "R10");
      idle(2);

      // R8: inverted window on R
      write_bounds(3'b001, 12'hC00, 12'h400);
      for (int x = 0; x < 4096; x += 37)
         cycle(1'b1, DW'(x), DW'(x), DW'(x), "R8");
      cycle(1'b1, 12'hFFF, 12'h000, 12'hBFF, "R8");
      idle(2);

      // R9: prog -> 8-bit window, pixels back to back across the change
      clamp_en = 1'b1; fmt_code = 3'd1;
      cycle(1'b1, 12'h000, 12'hFFF, 12'h000, "R9");
      cycle(1'b1, 12'h000, 12'hFFF, 12'h000, "R9");
      cycle(1'b1, 12'h000, 12'hFFF, 12'h000, "R9");
      cycle(1'b1, 12'h000, 12'hFFF, 12'h000, "R9");
      // R9: enabled -> disabled, then format change while disabled
      clamp_en = 1'b0;
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      fmt_code = 3'd2;
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      clamp_en = 1'b1;
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      cycle(1'b1, 12'h001, 12'hFFE, 12'h002, "R9");
      idle(4);

      check(exp_q.size() == 0, "R2", 36'(exp_q.size()), '0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule